// File: doc/BRIEF.md
# Prescaled Up/Down Timer Counter

An 8-bit counter that advances by one step for each enable pulse from a chosen clock source. The source is picked by a three-bit field in a control register. Six choices are taps of a free-running divider on the system clock. One choice divides an external sub-clock strobe by four. The last choice counts edges on an external event pin, after that pin has been synchronized to the system clock.

The count direction is set in one of three ways: fixed up, fixed down, or steered by a synchronized direction pin. When the counter wraps in either direction it sets a sticky wrap flag. Software clears the flag by writing zero to it.

Software reaches the block through a small register bus. Writes take effect on the clock edge. Reads are combinational and decoded from the address.

Top module: `updown_timer`

## Requirements
- R1: After reset, the control register reads 0x18, the counter reads 0x00 and the wrap flag reads 0. The register addresses are: 0 = control, 1 = counter, 2 = flag (bit 0).
- R2: Control bits [4:3] always read as 1, bit 7 always reads as 0, and writes to these three bits have no effect.
- R3: Control bits [2:0] select the step source. The encodings are 000 = system clock/8192, 001 = /2048, 010 = /512, 011 = /64, 100 = /16, 101 = /4, 110 = sub-clock strobe/4, 111 = external event. A divided source gives exactly k steps in any window of k×N system clock cycles.
- R4: Control bits [6:5] set the direction. 00 counts up, 01 counts down, and 1x follows the direction pin, where pin high counts down and pin low counts up.
- R5: In external-event mode, each rising edge of the event pin gives exactly one step when the edge-select input is 0. Each falling edge gives exactly one step when the edge-select input is 1.
- R6: While the pin-enable input is 0, the event pin produces no steps.
- R7: Counting up wraps from 0xFF to 0x00, and counting down wraps from 0x00 to 0xFF. Either wrap sets the flag, and the flag stays set until software clears it.
- R8: Writing 0 to flag bit 0 clears the flag. Writing 1 leaves the flag unchanged.
- R9: A write to the counter loads the written value. It takes priority over a step that falls in the same cycle, and that step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |
| sub_stb | input | 1 | Sub-clock strobe, one cycle per sub-clock tick |
| dir_pin | input | 1 | Direction pin: high = down, low = up |
| evt_pin | input | 1 | External event pin |
| evt_edge_sel | input | 1 | Edge to count: 0 = rising, 1 = falling |
| evt_pin_en | input | 1 | Enables the event pin as a step source |
| wrap_flag | output | 1 | Sticky flag set by a wrap in either direction |

## Verification
On every cycle, the assertions check the following. The reserved control bits read back correctly. The counter never moves by more than one step except on a load. A load always wins over a step. A wrap raises the flag, and the flag stays set until a clear write.

Other behaviour can only be shown by the bench's scenarios. This covers the exact divisor of each clock-select code and the sub-clock strobe divide-by-four. It also covers counting only the selected edge, the pin-enable gate, and the direction pin steering through its synchronizer.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

  typedef enum logic [2:0] {
    SRC_D8192 = 3'b000,
    SRC_D2048 = 3'b001,
    SRC_D512  = 3'b010,
    SRC_D64   = 3'b011,
    SRC_D16   = 3'b100,
    SRC_D4    = 3'b101,
    SRC_SUB   = 3'b110,
    SRC_EVT   = 3'b111
  } src_sel_e;

  typedef struct packed {
    logic [1:0] dmode;
    src_sel_e   src;
  } ctrl_t;
endpackage

// File: rtl/utmr_sync.sv
module utmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/utmr_prescaler.sv
module utmr_prescaler
  import utmr_pkg::*;
#(
  parameter int DIV_W   = 13,
  parameter int SUB_DIV = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sub_stb,
  input  src_sel_e src,
  output logic     tick
);
  localparam int NTAP  = 6;
  localparam int SUB_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam int TAP_W [NTAP] = '{DIV_W, DIV_W-2, DIV_W-4, DIV_W-7, DIV_W-9, DIV_W-11};

  logic [DIV_W-1:0] div_q, div_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [NTAP-1:0]  tap;
  logic             sub_tick;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam logic [DIV_W-1:0] MASK = DIV_W'((64'd1 << TAP_W[i]) - 64'd1);
    assign tap[i] = ((div_q & MASK) == MASK);
  end

  assign sub_tick = sub_stb && (sub_q == SUB_W'(SUB_DIV-1));

  always_comb begin
    sub_d = sub_q;
    if (sub_stb) sub_d = sub_tick ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

  always_comb begin
    case (src)
      SRC_D8192: tick = tap[0];
      SRC_D2048: tick = tap[1];
      SRC_D512:  tick = tap[2];
      SRC_D64:   tick = tap[3];
      SRC_D16:   tick = tap[4];
      SRC_D4:    tick = tap[5];
      SRC_SUB:   tick = sub_tick;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  input  logic         flag_clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      if (down) begin
        cnt_d = cnt_q - 1'b1;
        wrap  = (cnt_q == '0);
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = (cnt_q == '1);
      end
    end
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (wrap)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import utmr_pkg::*;
#(
  parameter int DIV_W   = 13,
  parameter int SUB_DIV = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sub_stb,
  input  logic              dir_pin,
  input  logic              evt_pin,
  input  logic              evt_edge_sel,
  input  logic              evt_pin_en,
  output logic              wrap_flag
);
  logic [1:0]        rst_sh_q;
  logic              rst_i;
  ctrl_t             ctrl_q, ctrl_d;
  logic              pre_tick, evt_tick, step, down;
  logic              dir_s, dir_r, dir_f;
  logic              evt_s, evt_r, evt_f;
  logic [DATA_W-1:0] cnt_q;
  logic              wr_ctrl, wr_cnt, wr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i = rst_sh_q[1];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_flag = wr_en && (addr == A_FLAG);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.dmode = wdata[6:5];
      ctrl_d.src   = src_sel_e'(wdata[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctrl_q <= '{dmode: 2'b00, src: SRC_D8192};
    else        ctrl_q <= ctrl_d;
  end

  utmr_sync #(.STAGES(SYNC_N)) u_dir_sync (
    .clk(clk), .rst_n(rst_i), .din(dir_pin),
    .dout(dir_s), .rise(dir_r), .fall(dir_f)
  );

  utmr_sync #(.STAGES(SYNC_N)) u_evt_sync (
    .clk(clk), .rst_n(rst_i), .din(evt_pin),
    .dout(evt_s), .rise(evt_r), .fall(evt_f)
  );

  utmr_prescaler #(.DIV_W(DIV_W), .SUB_DIV(SUB_DIV)) u_presc (
    .clk(clk), .rst_n(rst_i), .sub_stb(sub_stb),
    .src(ctrl_q.src), .tick(pre_tick)
  );

  assign evt_tick = (ctrl_q.src == SRC_EVT) && evt_pin_en &&
                    (evt_edge_sel ? evt_f : evt_r);
  assign step     = pre_tick | evt_tick;
  assign down     = ctrl_q.dmode[1] ? dir_s : ctrl_q.dmode[0];

  utmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_i),
    .load(wr_cnt), .load_val(wdata),
    .step(step), .down(down),
    .flag_clr(wr_flag && !wdata[0]),
    .cnt(cnt_q), .flag(wrap_flag)
  );

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {1'b0, ctrl_q.dmode, 2'b11, ctrl_q.src};
      A_CNT:   rdata = cnt_q;
      A_FLAG:  rdata = {{(DATA_W-1){1'b0}}, wrap_flag};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/utmr_chk.sv
module utmr_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] cnt_q,
  input logic       wrap_flag
);
  // R2
  rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (addr == 2'd0) |-> (rdata[4:3] == 2'b11 && rdata[7] == 1'b0));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && addr == 2'd1) |=> (cnt_q == $past(wdata)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !(wr_en && addr == 2'd1) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1 ||
       cnt_q == $past(cnt_q) - 8'd1));

  // R7
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!(wr_en && addr == 2'd1) &&
     ((cnt_q == 8'hFF) || (cnt_q == 8'h00))) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q != 8'h00 && cnt_q != 8'hFF) ||
       wrap_flag));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (wrap_flag && !(wr_en && addr == 2'd2 && !wdata[0])) |=> wrap_flag);
endmodule

bind updown_timer utmr_chk u_chk (
  .clk(clk), .rst_i(rst_i), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .cnt_q(cnt_q), .wrap_flag(wrap_flag)
);

// File: tb/updown_timer_bench.sv
`timescale 1ns/1ps
module updown_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sub_stb = 1'b0, dir_pin = 1'b0, evt_pin = 1'b0;
  logic       evt_edge_sel = 1'b0, evt_pin_en = 1'b0;
  logic       wrap_flag;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  updown_timer u_updown_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sub_stb(sub_stb), .dir_pin(dir_pin), .evt_pin(evt_pin),
    .evt_edge_sel(evt_edge_sel), .evt_pin_en(evt_pin_en), .wrap_flag(wrap_flag)
  );

  function automatic logic [7:0] mk_ctrl(input logic [1:0] dm, input logic [2:0] src);
    return {1'b0, dm, 2'b00, src};
  endfunction

  function automatic logic [7:0] step_val(input logic [7:0] v, input bit dn, input int n);
    return dn ? v - 8'(n) : v + 8'(n);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input int n);
    for (int i = 0; i < n; i++) begin
      evt_pin = 1'b1; idle(3);
      evt_pin = 1'b0; idle(3);
    end
    idle(3);
  endtask

  task automatic window(input logic [2:0] src, input int div, input int k, input string tag);
    logic [7:0] a, b;
    wr(2'd0, mk_ctrl(2'b00, src));
    rd(2'd1, a);
    idle(div * k);
    rd(2'd1, b);
    chk(b == step_val(a, 0, k), tag, b, step_val(a, 0, k));
  endtask

  initial begin
    logic [7:0] v, e, base;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd0, v); chk(v == 8'h18, "R1 ctrl", v, 8'h18);
    rd(2'd1, v); chk(v == 8'h00, "R1 cnt", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 flag", v, 0);

    // R2 reserved bits ignore writes
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 8'h18, "R2 write 00", v, 8'h18);
    wr(2'd0, 8'hE7); rd(2'd0, v); chk(v == 8'h7F, "R2 write E7", v, 8'h7F);
    wr(2'd0, 8'h00);

    // R3 divisor windows
    window(3'b101, 4, 100, "R3 div4");
    window(3'b100, 16, 50, "R3 div16");
    window(3'b011, 64, 20, "R3 div64");
    window(3'b010, 512, 6, "R3 div512");
    window(3'b001, 2048, 3, "R3 div2048");
    window(3'b000, 8192, 2, "R3 div8192");

    // R3 sub-clock strobe divided by four
    wr(2'd0, mk_ctrl(2'b00, 3'b110));
    rd(2'd1, base);
    for (int i = 0; i < 12; i++) begin
      sub_stb = 1'b1; idle(1); sub_stb = 1'b0; idle(2);
    end
    rd(2'd1, v); chk(v == base + 8'd3, "R3 sub", v, base + 8'd3);

    // R4 fixed down, pin up, pin down
    wr(2'd0, mk_ctrl(2'b01, 3'b101)); rd(2'd1, base); idle(400);
    rd(2'd1, v); chk(v == base - 8'd100, "R4 fixed down", v, base - 8'd100);
    dir_pin = 1'b0; wr(2'd0, mk_ctrl(2'b10, 3'b101)); idle(4);
    rd(2'd1, base); idle(400);
    rd(2'd1, v); chk(v == base + 8'd100, "R4 pin low up", v, base + 8'd100);
    dir_pin = 1'b1; idle(4);
    rd(2'd1, base); idle(400);
    rd(2'd1, v); chk(v == base - 8'd100, "R4 pin high down", v, base - 8'd100);
    dir_pin = 1'b0;

    // R7 up wrap and R8 clear
    wr(2'd2, 8'h00);
    wr(2'd0, mk_ctrl(2'b00, 3'b101)); wr(2'd1, 8'hFE); idle(12);
    rd(2'd1, v); chk(v == 8'h01, "R7 up wrap", v, 1);
    rd(2'd2, v); chk(v == 8'h01, "R7 flag up", v, 1);
    wr(2'd0, mk_ctrl(2'b00, 3'b111)); idle(20);
    rd(2'd2, v); chk(v == 8'h01, "R7 sticky", v, 1);
    wr(2'd2, 8'h01); rd(2'd2, v); chk(v == 8'h01, "R8 write1 keeps", v, 1);
    wr(2'd2, 8'h00); rd(2'd2, v); chk(v == 8'h00, "R8 clear", v, 0);
    wr(2'd2, 8'h01); rd(2'd2, v); chk(v == 8'h00, "R8 write1 no set", v, 0);

    // R7 down wrap
    wr(2'd0, mk_ctrl(2'b01, 3'b101)); wr(2'd1, 8'h01); idle(12);
    rd(2'd1, v); chk(v == 8'hFE, "R7 down wrap", v, 8'hFE);
    rd(2'd2, v); chk(v == 8'h01, "R7 flag down", v, 1);
    wr(2'd2, 8'h00);

    // R5 rising and falling edges
    wr(2'd0, mk_ctrl(2'b00, 3'b111)); evt_pin_en = 1'b1; evt_edge_sel = 1'b0;
    wr(2'd1, 8'h10); pulse_evt(7);
    rd(2'd1, v); chk(v == 8'h17, "R5 rising", v, 8'h17);
    evt_edge_sel = 1'b1; idle(2); wr(2'd1, 8'h20); pulse_evt(5);
    rd(2'd1, v); chk(v == 8'h25, "R5 falling", v, 8'h25);
    evt_edge_sel = 1'b0; idle(2);

    // R6 pin enable clear
    evt_pin_en = 1'b0; wr(2'd1, 8'h40); pulse_evt(6);
    rd(2'd1, v); chk(v == 8'h40, "R6 disabled", v, 8'h40);
    evt_pin_en = 1'b1;

    // R9 load collides with an event step
    wr(2'd1, 8'h00);
    @(negedge clk); evt_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    idle(3); evt_pin = 1'b0; idle(4);
    rd(2'd1, v); chk(v == 8'h55, "R9 load wins", v, 8'h55);

    // R4 R5 R7 random event runs
    for (int it = 0; it < 40; it++) begin
      logic [1:0] dm;
      logic [7:0] ld;
      bit dn, wrapped;
      int n;
      dm = 2'($urandom_range(0, 3));
      dir_pin = 1'($urandom_range(0, 1));
      ld = (it % 4 == 0) ? 8'hFE : (it % 4 == 1) ? 8'h01 : 8'($urandom);
      n = $urandom_range(0, 5);
      dn = dm[1] ? dir_pin : dm[0];
      wr(2'd2, 8'h00);
      wr(2'd0, mk_ctrl(dm, 3'b111));
      wr(2'd1, ld); idle(3);
      pulse_evt(n);
      e = step_val(ld, dn, n);
      wrapped = dn ? (int'(ld) < n) : (int'(ld) + n > 255);
      rd(2'd1, v); chk(v == e, "R4 random count", v, e);
      rd(2'd2, v); chk(v[0] == wrapped, "R7 random flag", v, wrapped);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule